// File: doc/BRIEF.md
# DRAM Refresh and Initialization Manager

This block looks after a DRAM's upkeep so that the access sequencer beside it only has to handle reads and writes. After reset it keeps both strobes idle through a long power-up pause. It then runs a series of initialization cycles, and every one of them is a CAS-before-RAS refresh. When those are done it raises `ready`. From then on an interval timer adds one owed refresh every `REF_INTERVAL` cycles. The block asks for the memory bus with `bus_req`, waits for `bus_gnt`, and then pays off every owed refresh in one back-to-back run. CAS stays low between cycles of the same run. Up to `BACKLOG_MAX` refreshes may be owed while the sequencer keeps the bus. At that limit `refresh_urgent` tells the sequencer to hand over the bus.

A self-refresh request (`sr_req`, a level) takes precedence over owed refreshes. Once the bus is granted, the block drops CAS, then RAS, and keeps both low for at least `SR_MIN_CYC` cycles, and longer if `sr_req` is still high. On exit it raises both strobes in the same cycle and waits an exit hold. It then runs a burst of `BURST_ROWS` refresh cycles before it hands the bus back. The address bus is never touched, because every refresh uses the DRAM's internal row counter.

The interface is made of control and status pins only. No data stream passes through the block, so there is no valid/ready channel. `bus_req`/`bus_gnt` is a level handshake: the sequencer holds `bus_gnt` high for as long as `bus_req` stays high. The block drives the strobes only while it holds the grant, or before `ready` has first risen.

Top module: `dram_upkeep`

## Requirements
- R1: While reset is asserted, `ras_n` and `cas_n` are high, and `bus_req`, `ready`, `sr_active` and `refresh_urgent` are low.
- R2: For at least `PWR_WAIT_CYC` cycles after reset is released, neither strobe goes low.
- R3: After the pause the block runs exactly `INIT_PULSES` refresh cycles while keeping `bus_req` low. `ready` rises only after the last of them.
- R4: In every refresh cycle CAS goes low at least `T_CSR` cycles before RAS falls, unless it is already low from the previous cycle. RAS then stays low for exactly `T_RAS` cycles. RAS is never low while CAS is high.
- R5: Within one run of consecutive refresh cycles (init, drain or burst), CAS stays low from one cycle to the next. The first cycle of a run starts with CAS high.
- R6: One refresh becomes owed every `REF_INTERVAL` cycles, counted from the edge where `ready` rises. `bus_req` rises one cycle after a refresh becomes owed. No strobe moves after `ready` has first risen unless `bus_req` and `bus_gnt` are both high.
- R7: Owed refreshes pile up to `BACKLOG_MAX`, and `refresh_urgent` is high while that limit is reached. On grant, all owed refreshes run in one ownership. A refresh that falls due during the run is added to the same run.
- R8: When nothing is owed after a run, `bus_req` falls and `ready` stays high.
- R9: On `sr_req`, `ready` falls and `bus_req` rises. After the grant, CAS falls `T_CSR` cycles before RAS. `sr_active` is high exactly while both strobes are held low.
- R10: Self-refresh lasts at least `SR_MIN_CYC` cycles even if `sr_req` drops earlier. On exit RAS and CAS rise in the same cycle and stay high for at least `T_CHS` cycles.
- R11: After self-refresh exit, `BURST_ROWS` refresh cycles run while the bus is held. `ready` then returns with the owed count cleared, so `bus_req` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_gnt | input | 1 | Bus granted by the access sequencer (level) |
| sr_req | input | 1 | Level request to enter and stay in self-refresh |
| bus_req | output | 1 | Bus requested or held by this block |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| ready | output | 1 | Initialized and open for normal accesses |
| sr_active | output | 1 | DRAM is in self-refresh |
| refresh_urgent | output | 1 | Owed refreshes have reached the backlog limit |

## Verification
Two functions can fall in the same cycle: the interval timer adding an owed refresh, and a finished refresh cycle removing one during a drain. The bench holds the grant back until the backlog is full. It then grants the bus a fixed number of cycles before the next timer tick, so the tick lands in the middle of the drain. The scoreboard must then see four refresh cycles in one ownership rather than three, each with correct CAS lead and RAS width, and `bus_req` must fall only after the last one.

// File: rtl/dram_upkeep_pkg.sv
package dram_upkeep_pkg;

  typedef enum logic [3:0] {
    ST_PWR,
    ST_INIT,
    ST_IDLE,
    ST_RREQ,
    ST_REF,
    ST_SREQ,
    ST_SR_SETUP,
    ST_SR_HOLD,
    ST_SR_EXIT,
    ST_BURST
  } upkeep_st_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_LOW,
    PH_PRE
  } pulse_ph_e;

endpackage

// File: rtl/upkeep_sched.sv
module upkeep_sched #(
  parameter int INTERVAL = 1950,
  parameter int BACKLOG  = 4,
  localparam int OW = $clog2(BACKLOG + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          clr,
  input  logic          take,
  output logic [OW-1:0] owed,
  output logic          due,
  output logic          urgent
);
  localparam int TW = $clog2(INTERVAL + 1);
  localparam logic [TW-1:0] T_LD = TW'(INTERVAL - 1);

  logic [TW-1:0] tmr;
  logic          tick;
  logic          inc, dec;

  assign tick   = en && (tmr == '0);
  assign due    = (owed != '0);
  assign urgent = (owed == OW'(BACKLOG));
  assign inc    = tick && !urgent;
  assign dec    = take && due;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr  <= T_LD;
      owed <= '0;
    end else if (clr) begin
      tmr  <= T_LD;
      owed <= '0;
    end else begin
      if (en) tmr <= tick ? T_LD : tmr - 1'b1;
      if (inc && !dec)      owed <= owed + 1'b1;
      else if (dec && !inc) owed <= owed - 1'b1;
    end
  end
endmodule

// File: rtl/cbr_pulse.sv
module cbr_pulse
  import dram_upkeep_pkg::*;
#(
  parameter int T_CSR = 2,
  parameter int T_RAS = 6,
  parameter int T_RP  = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic hold,
  output logic ras_n,
  output logic cas_n,
  output logic busy,
  output logic done
);
  localparam int TMAX = (T_CSR > T_RAS) ? ((T_CSR > T_RP) ? T_CSR : T_RP)
                                        : ((T_RAS > T_RP) ? T_RAS : T_RP);
  localparam int CW = $clog2(TMAX + 1);
  localparam logic [CW-1:0] CSR_LD = CW'(T_CSR - 1);
  localparam logic [CW-1:0] RAS_LD = CW'(T_RAS - 1);
  localparam logic [CW-1:0] RP_LD  = CW'(T_RP - 1);

  pulse_ph_e     ph;
  logic [CW-1:0] cnt;
  logic          ras_q, cas_q;

  assign ras_n = ras_q;
  assign cas_n = cas_q;
  assign busy  = (ph != PH_IDLE);
  assign done  = (ph == PH_PRE) && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph    <= PH_IDLE;
      cnt   <= '0;
      ras_q <= 1'b1;
      cas_q <= 1'b1;
    end else begin
      unique case (ph)
        PH_IDLE: begin
          if (start) begin
            if (!cas_q) begin
              // CAS still low from the previous cycle: setup already met
              ras_q <= 1'b0;
              cnt   <= RAS_LD;
              ph    <= PH_LOW;
            end else begin
              cas_q <= 1'b0;
              cnt   <= CSR_LD;
              ph    <= PH_SETUP;
            end
          end else if (!hold) begin
            cas_q <= 1'b1;
          end
        end
        PH_SETUP: begin
          if (cnt == '0) begin
            ras_q <= 1'b0;
            cnt   <= RAS_LD;
            ph    <= PH_LOW;
          end else cnt <= cnt - 1'b1;
        end
        PH_LOW: begin
          if (cnt == '0) begin
            ras_q <= 1'b1;
            cas_q <= !hold;
            cnt   <= RP_LD;
            ph    <= PH_PRE;
          end else cnt <= cnt - 1'b1;
        end
        PH_PRE: begin
          if (cnt == '0) ph <= PH_IDLE;
          else cnt <= cnt - 1'b1;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dram_upkeep.sv
module dram_upkeep
  import dram_upkeep_pkg::*;
#(
  parameter int PWR_WAIT_CYC = 25000,
  parameter int INIT_PULSES  = 8,
  parameter int REF_INTERVAL = 1950,
  parameter int BACKLOG_MAX  = 4,
  parameter int BURST_ROWS   = 4096,
  parameter int SR_MIN_CYC   = 12500,
  parameter int T_CSR        = 2,
  parameter int T_RAS        = 6,
  parameter int T_RP         = 5,
  parameter int T_CHS        = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_gnt,
  input  logic sr_req,
  output logic bus_req,
  output logic ras_n,
  output logic cas_n,
  output logic ready,
  output logic sr_active,
  output logic refresh_urgent
);
  localparam int T_A  = (PWR_WAIT_CYC > SR_MIN_CYC) ? PWR_WAIT_CYC : SR_MIN_CYC;
  localparam int T_B  = (T_CHS > T_CSR) ? T_CHS : T_CSR;
  localparam int TMAX = (T_A > T_B) ? T_A : T_B;
  localparam int TMW  = $clog2(TMAX + 1);
  localparam int LMAX = (INIT_PULSES > BURST_ROWS) ? INIT_PULSES : BURST_ROWS;
  localparam int LW   = $clog2(LMAX + 1);
  localparam int OW   = $clog2(BACKLOG_MAX + 1);

  upkeep_st_e     state;
  logic [TMW-1:0] tmr;
  logic [LW-1:0]  left;
  logic           sr_ras_q, sr_cas_q;

  logic           p_start, p_hold, p_busy, p_done, p_ras_n, p_cas_n;
  logic [OW-1:0]  owed;
  logic           due, sch_en, sch_clr, take;
  logic           run_seq, sr_drive;

  assign run_seq  = (state == ST_INIT) || (state == ST_BURST);
  assign sr_drive = state inside {ST_SR_SETUP, ST_SR_HOLD, ST_SR_EXIT};
  assign sch_en   = state inside {ST_IDLE, ST_RREQ, ST_REF};
  assign sch_clr  = run_seq && (left == '0) && !p_busy;
  assign take     = (state == ST_REF) && p_done;

  always_comb begin
    p_start = 1'b0;
    p_hold  = 1'b0;
    if (run_seq) begin
      p_start = (left != '0);
      p_hold  = (left > LW'(1));
    end else if (state == ST_REF) begin
      p_start = due;
      p_hold  = (owed > OW'(1));
    end
  end

  upkeep_sched #(.INTERVAL(REF_INTERVAL), .BACKLOG(BACKLOG_MAX)) u_sched (
    .clk(clk), .rst_n(rst_n), .en(sch_en), .clr(sch_clr), .take(take),
    .owed(owed), .due(due), .urgent(refresh_urgent)
  );

  cbr_pulse #(.T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP)) u_pulse (
    .clk(clk), .rst_n(rst_n), .start(p_start), .hold(p_hold),
    .ras_n(p_ras_n), .cas_n(p_cas_n), .busy(p_busy), .done(p_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_PWR;
      tmr      <= TMW'(PWR_WAIT_CYC - 1);
      left     <= '0;
      sr_ras_q <= 1'b1;
      sr_cas_q <= 1'b1;
    end else begin
      unique case (state)
        ST_PWR: begin
          if (tmr == '0) begin
            left  <= LW'(INIT_PULSES);
            state <= ST_INIT;
          end else tmr <= tmr - 1'b1;
        end
        ST_INIT, ST_BURST: begin
          if (p_done) left <= left - 1'b1;
          if (left == '0 && !p_busy) state <= ST_IDLE;
        end
        ST_IDLE: begin
          if (sr_req)   state <= ST_SREQ;
          else if (due) state <= ST_RREQ;
        end
        ST_RREQ: if (bus_gnt) state <= ST_REF;
        ST_REF:  if (!due && !p_busy) state <= ST_IDLE;
        ST_SREQ: begin
          if (bus_gnt) begin
            sr_cas_q <= 1'b0;
            tmr      <= TMW'(T_CSR - 1);
            state    <= ST_SR_SETUP;
          end
        end
        ST_SR_SETUP: begin
          if (tmr == '0) begin
            sr_ras_q <= 1'b0;
            tmr      <= TMW'(SR_MIN_CYC - 1);
            state    <= ST_SR_HOLD;
          end else tmr <= tmr - 1'b1;
        end
        ST_SR_HOLD: begin
          if (tmr != '0) tmr <= tmr - 1'b1;
          else if (!sr_req) begin
            sr_ras_q <= 1'b1;
            sr_cas_q <= 1'b1;
            tmr      <= TMW'(T_CHS - 1);
            state    <= ST_SR_EXIT;
          end
        end
        ST_SR_EXIT: begin
          if (tmr == '0) begin
            left  <= LW'(BURST_ROWS);
            state <= ST_BURST;
          end else tmr <= tmr - 1'b1;
        end
        default: state <= ST_PWR;
      endcase
    end
  end

  assign ras_n     = sr_drive ? sr_ras_q : p_ras_n;
  assign cas_n     = sr_drive ? sr_cas_q : p_cas_n;
  assign ready     = sch_en;
  assign sr_active = (state == ST_SR_HOLD);
  assign bus_req   = state inside {ST_RREQ, ST_REF, ST_SREQ, ST_SR_SETUP,
                                   ST_SR_HOLD, ST_SR_EXIT, ST_BURST};
endmodule

// File: rtl/dram_upkeep_chk.sv
module dram_upkeep_chk #(
  parameter int PWR_WAIT_CYC = 25000
) (
  input logic clk,
  input logic rst_n,
  input logic bus_gnt,
  input logic bus_req,
  input logic ras_n,
  input logic cas_n,
  input logic ready,
  input logic sr_active,
  input logic refresh_urgent
);
  int   since_rst;
  logic seen_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst  <= 0;
      seen_ready <= 1'b0;
    end else begin
      if (since_rst < PWR_WAIT_CYC) since_rst <= since_rst + 1;
      if (ready) seen_ready <= 1'b1;
    end
  end

  p_pwr_pause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst < PWR_WAIT_CYC) |-> (ras_n && cas_n))
    else $error("strobe moved during power-up pause");

  p_cbr_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> !cas_n)
    else $error("RAS low with CAS high");

  p_cas_lead_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $past(!cas_n))
    else $error("RAS fell without CAS already low");

  p_owned_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_ready && (!$stable(ras_n) || !$stable(cas_n))) |-> (bus_req && bus_gnt))
    else $error("strobe moved without bus ownership");

  p_urgent_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_urgent |=> bus_req)
    else $error("backlog full but bus not requested");

  p_sr_owned_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sr_active |-> (bus_req && !ready && !ras_n && !cas_n))
    else $error("self-refresh state inconsistent");

  p_sr_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sr_active) |-> (ras_n && cas_n))
    else $error("self-refresh exit did not raise both strobes");
endmodule

bind dram_upkeep dram_upkeep_chk #(.PWR_WAIT_CYC(PWR_WAIT_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_gnt(bus_gnt), .bus_req(bus_req),
  .ras_n(ras_n), .cas_n(cas_n), .ready(ready), .sr_active(sr_active),
  .refresh_urgent(refresh_urgent)
);

// File: tb/dram_upkeep_test.sv
module dram_upkeep_test;
  localparam int PWR  = 60;
  localparam int INIP = 8;
  localparam int IVL  = 80;
  localparam int BKL  = 3;
  localparam int ROWS = 12;
  localparam int SRM  = 40;
  localparam int CSR  = 2;
  localparam int RASW = 3;
  localparam int RP   = 2;
  localparam int CHS  = 3;

  logic clk = 1'b0, rst_n = 1'b0, bus_gnt = 1'b0, sr_req = 1'b0;
  logic bus_req, ras_n, cas_n, ready, sr_active, refresh_urgent;

  always #4 clk = ~clk;

  dram_upkeep #(
    .PWR_WAIT_CYC(PWR), .INIT_PULSES(INIP), .REF_INTERVAL(IVL),
    .BACKLOG_MAX(BKL), .BURST_ROWS(ROWS), .SR_MIN_CYC(SRM),
    .T_CSR(CSR), .T_RAS(RASW), .T_RP(RP), .T_CHS(CHS)
  ) uut (
    .clk(clk), .rst_n(rst_n), .bus_gnt(bus_gnt), .sr_req(sr_req),
    .bus_req(bus_req), .ras_n(ras_n), .cas_n(cas_n), .ready(ready),
    .sr_active(sr_active), .refresh_urgent(refresh_urgent)
  );

  // expected RAS pulse: sr = self-refresh pulse, chain 0 new / 1 CAS kept low / 2 either
  typedef struct { bit sr; int chain; } exp_t;
  exp_t exp_q[$];

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic push(input bit sr, input int chain);
    exp_t e;
    e.sr = sr;
    e.chain = chain;
    exp_q.push_back(e);
  endtask

  // ---------------- monitor ----------------
  logic prev_ras = 1'b1, prev_cas = 1'b1;
  int   cas_run = 0, ras_run = 0, cyc = 0, hi_cnt = 0;
  bit   cas_rose = 1'b1, first_seen = 1'b0, exit_mark = 1'b0, cur_sr = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      exp_t cur;
      cyc++;
      cas_run = cas_n ? 0 : cas_run + 1;
      if (!ras_n && cas_n) chk(1'b0, "R4", "RAS low with CAS high", 1, 0);
      if (!first_seen && !cas_n) begin
        first_seen = 1'b1;
        chk(cyc >= PWR, "R2", "first CAS fall cycle", cyc, PWR);
      end
      if (exit_mark && prev_cas && !cas_n) begin
        chk(hi_cnt >= CHS, "R10", "strobes high after exit", hi_cnt, CHS);
        exit_mark = 1'b0;
      end
      if (prev_ras && !ras_n) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6", "unexpected RAS pulse", 1, 0);
          cur_sr = 1'b0;
        end else begin
          cur = exp_q.pop_front();
          cur_sr = cur.sr;
          chk(cas_run >= CSR + 1, "R4", "CAS lead before RAS", cas_run - 1, CSR);
          if (cur.chain != 2)
            chk(int'(!cas_rose) == cur.chain, "R5", "CAS held between cycles",
                int'(!cas_rose), cur.chain);
        end
      end
      if (!prev_ras && ras_n) begin
        if (cur_sr) begin
          chk(ras_run >= SRM, "R10", "self-refresh low length", ras_run, SRM);
          chk(cas_n == 1'b1, "R10", "CAS rises with RAS", int'(cas_n), 1);
          exit_mark = 1'b1;
          hi_cnt = 0;
        end else begin
          chk(ras_run == RASW, "R4", "RAS low length", ras_run, RASW);
        end
        cas_rose = 1'b0;
      end
      if (!prev_cas && cas_n) cas_rose = 1'b1;
      if (exit_mark && cas_n) hi_cnt++;
      ras_run = ras_n ? 0 : ras_run + 1;
      prev_ras = ras_n;
      prev_cas = cas_n;
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "WDOG", "run did not finish", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  // ---------------- driver ----------------
  initial begin
    int t;
    bit saw_req;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ras_n == 1'b1, "R1", "ras_n in reset", int'(ras_n), 1);
    chk(cas_n == 1'b1, "R1", "cas_n in reset", int'(cas_n), 1);
    chk(bus_req == 1'b0, "R1", "bus_req in reset", int'(bus_req), 0);
    chk(ready == 1'b0, "R1", "ready in reset", int'(ready), 0);
    chk(sr_active == 1'b0, "R1", "sr_active in reset", int'(sr_active), 0);
    chk(refresh_urgent == 1'b0, "R1", "urgent in reset", int'(refresh_urgent), 0);

    // R3 init: one fresh cycle then chained ones
    push(1'b0, 0);
    for (int i = 1; i < INIP; i++) push(1'b0, 1);
    rst_n = 1'b1;
    saw_req = 1'b0;
    for (int i = 0; i < 2000 && !ready; i++) begin
      @(negedge clk);
      saw_req |= bus_req;
    end
    chk(ready == 1'b1, "R3", "ready after init", int'(ready), 1);
    chk(!saw_req, "R3", "bus_req during init", int'(saw_req), 0);
    chk(exp_q.size() == 0, "R3", "init cycles missing", exp_q.size(), 0);

    // R6 first owed refresh timing, grant withheld
    t = 0;
    while (!bus_req && t < IVL + 10) begin @(negedge clk); t++; end
    chk(t == IVL + 1, "R6", "bus_req rise cycle", t, IVL + 1);
    while (!refresh_urgent && t < 4 * IVL) begin @(negedge clk); t++; end
    chk(t == 3 * IVL, "R7", "urgent rise cycle", t, 3 * IVL);
    repeat (2) @(negedge clk);
    chk(refresh_urgent && bus_req, "R7", "urgent and request held", int'(refresh_urgent), 1);

    // R7 drain of full backlog
    push(1'b0, 0); push(1'b0, 1); push(1'b0, 1);
    bus_gnt = 1'b1;
    for (int i = 0; i < 200 && bus_req; i++) @(negedge clk);
    bus_gnt = 1'b0;
    chk(exp_q.size() == 0, "R7", "drain cycles missing", exp_q.size(), 0);
    chk(bus_req == 1'b0, "R8", "bus_req after drain", int'(bus_req), 0);
    chk(ready == 1'b1, "R8", "ready after drain", int'(ready), 1);
    chk(refresh_urgent == 1'b0, "R7", "urgent after drain", int'(refresh_urgent), 0);

    // R7 collision: timer tick lands inside the drain
    for (int i = 0; i < 4 * IVL && !refresh_urgent; i++) @(negedge clk);
    repeat (IVL - 14) @(negedge clk);
    push(1'b0, 0); push(1'b0, 1); push(1'b0, 1); push(1'b0, 2);
    bus_gnt = 1'b1;
    for (int i = 0; i < 200 && bus_req; i++) @(negedge clk);
    bus_gnt = 1'b0;
    chk(exp_q.size() == 0, "R7", "tick during drain not served", exp_q.size(), 0);
    chk(bus_req == 1'b0, "R8", "bus_req after collision drain", int'(bus_req), 0);

    // R9 self-refresh request
    sr_req = 1'b1;
    repeat (3) @(negedge clk);
    chk(ready == 1'b0, "R9", "ready during sr request", int'(ready), 0);
    chk(bus_req == 1'b1, "R9", "bus_req during sr request", int'(bus_req), 1);
    push(1'b1, 0);
    push(1'b0, 0);
    for (int i = 1; i < ROWS; i++) push(1'b0, 1);
    bus_gnt = 1'b1;
    for (int i = 0; i < 50 && !sr_active; i++) @(negedge clk);
    chk(sr_active == 1'b1, "R9", "sr_active after grant", int'(sr_active), 1);
    chk(!ras_n && !cas_n, "R9", "strobes low in sr", int'(ras_n), 0);
    repeat (5) @(negedge clk);
    sr_req = 1'b0;
    repeat (10) @(negedge clk);
    chk(sr_active == 1'b1, "R10", "sr held past early release", int'(sr_active), 1);
    for (int i = 0; i < SRM + 50 && sr_active; i++) @(negedge clk);
    chk(ras_n && cas_n, "R10", "strobes high on exit", int'(ras_n & cas_n), 1);

    // R11 burst after exit
    for (int i = 0; i < ROWS * 10 + 50 && !ready; i++) begin
      @(negedge clk);
      if (!ready && !bus_req) chk(1'b0, "R11", "bus released during burst", 0, 1);
    end
    chk(ready == 1'b1, "R11", "ready after burst", int'(ready), 1);
    chk(exp_q.size() == 0, "R11", "burst cycles missing", exp_q.size(), 0);
    @(negedge clk);
    chk(bus_req == 1'b0, "R11", "owed cleared after burst", int'(bus_req), 0);

    // R6 steady interval with grant always given
    push(1'b0, 0); push(1'b0, 0);
    repeat (2 * IVL + 20) @(negedge clk);
    chk(exp_q.size() == 0, "R6", "periodic cycles missing", exp_q.size(), 0);
    chk(bus_req == 1'b0, "R8", "bus_req idle after periodic", int'(bus_req), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule